// File: doc/BRIEF.md
# Program Bank and Mirroring Control

This block sits on the cartridge side of an 8-bit CPU bus and turns CPU writes into ROM banking state. Three registers are reachable by writes to exact addresses in the upper half of the 64 KB space. Two of them each hold an 8-bit bank number, one for the 8 KB CPU window starting at 0x8000 and one for the window starting at 0xA000. The third holds a two-bit nametable mirroring code.

The windows at 0xC000 and 0xE000 are not switchable. They always show the last two 8 KB banks of the fitted ROM, derived from a bank-count input and wrapped to the implemented bank-number width. The block also flags CPU accesses to the 8 KB work-RAM area at 0x6000–0x7FFF, whether the access is a read or a write.

The upper physical ROM address bits for every window come straight from the four bank outputs. The RAM select and mirroring code are used by the surrounding memory logic.

Top module: `prg_bank_ctl`

## Requirements
- R1: A write cycle with address exactly 0x8010 stores all 8 data bits as the bank of the 0x8000 window, visible on `win8_bank` after that clock edge.
- R2: A write cycle with address exactly 0xA010 stores all 8 data bits as the bank of the 0xA000 window, visible on `winA_bank` after that clock edge.
- R3: `winC_bank` equals (rom_banks − 2) and `winE_bank` equals (rom_banks − 1), each taken modulo 2^IMPL_W (IMPL_W = 6 by default) with all higher output bits zero, and each follows `rom_banks` combinationally.
- R4: A write cycle with address exactly 0x9400 stores data bits 1:0 as the mirroring code. Data bits 7:2 are ignored.
- R5: `mirror_mode` codes are 0 = vertical, 1 = horizontal, 2 = single page A, 3 = single page B, and the stored code is presented unchanged.
- R6: `wram_sel` is 1 exactly when cpu_addr lies in 0x6000–0x7FFF (address bits 15:13 = 3'b011), combinationally and regardless of `cpu_wr`.
- R7: Writes to any other address (including 0x8011, 0x8000, 0xA000, 0x9401, 0xC010) and cycles with `cpu_wr` low leave all three registers unchanged.
- R8: While `rst` is high at a clock edge, both bank registers and the mirroring code clear to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | Write strobe, one cycle per write |
| rom_banks | input | 9 | Number of 8 KB ROM banks fitted |
| win8_bank | output | 8 | Bank for window 0x8000 |
| winA_bank | output | 8 | Bank for window 0xA000 |
| winC_bank | output | 8 | Bank for window 0xC000 (second to last) |
| winE_bank | output | 8 | Bank for window 0xE000 (last) |
| wram_sel | output | 1 | Work-RAM window hit |
| mirror_mode | output | 2 | Mirroring code |

## Verification
Bank writes use all-ones, all-zeros and alternating patterns. This shows that every data bit reaches its register and that the two switchable windows do not share storage. Writes to addresses one bit away from each register address, and strobes held low over a matching address, separate an exact match from a partial decode. The mirroring register gets all four codes with junk in the upper data bits. Bank counts of 1, 16, 64 and 128 show whether the fixed windows wrap at the implemented width.

// File: rtl/prg_ctl_pkg.sv
package prg_ctl_pkg;

    parameter int unsigned PKG_BANK_W = 8;

    typedef enum logic [1:0] {
        MIR_VERT   = 2'd0,
        MIR_HORZ   = 2'd1,
        MIR_PAGE_A = 2'd2,
        MIR_PAGE_B = 2'd3
    } mirror_e;

    typedef struct packed {
        logic [PKG_BANK_W-1:0] win8;
        logic [PKG_BANK_W-1:0] winA;
        mirror_e               mir;
    } ctl_regs_t;

endpackage

// File: rtl/prg_addr_decode.sv
module prg_addr_decode #(
    parameter int unsigned ADDR_W    = 16,
    parameter logic [15:0] A_WIN8    = 16'h8010,
    parameter logic [15:0] A_WINA    = 16'hA010,
    parameter logic [15:0] A_MIR     = 16'h9400,
    parameter int unsigned RAM_TAG_W = 3,
    parameter logic [2:0]  RAM_TAG   = 3'b011
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    output logic              ld_win8_o,
    output logic              ld_winA_o,
    output logic              ld_mir_o,
    output logic              wram_sel_o
);
    localparam int unsigned TAG_LSB = ADDR_W - RAM_TAG_W;

    always_comb begin
        ld_win8_o  = wr_i && (addr_i == A_WIN8);
        ld_winA_o  = wr_i && (addr_i == A_WINA);
        ld_mir_o   = wr_i && (addr_i == A_MIR);
        wram_sel_o = (addr_i[ADDR_W-1:TAG_LSB] == RAM_TAG);
    end

endmodule

// File: rtl/prg_bank_regs.sv
module prg_bank_regs
    import prg_ctl_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [PKG_BANK_W-1:0] data_i,
    input  logic                  ld_win8_i,
    input  logic                  ld_winA_i,
    input  logic                  ld_mir_i,
    output ctl_regs_t             regs_o
);
    ctl_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (ld_win8_i) r_d.win8 = data_i;
        if (ld_winA_i) r_d.winA = data_i;
        if (ld_mir_i)  r_d.mir  = mirror_e'(data_i[1:0]);
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign regs_o = r_q;

    AST_WIN8_LOAD: assert property (@(posedge clk) disable iff (rst)
        (!rst && ld_win8_i) |=> (r_q.win8 == $past(data_i)))
        else $error("win8 load mismatch"); // R1
    AST_WINA_LOAD: assert property (@(posedge clk) disable iff (rst)
        (!rst && ld_winA_i) |=> (r_q.winA == $past(data_i)))
        else $error("winA load mismatch"); // R2
    AST_MIR_LOAD: assert property (@(posedge clk) disable iff (rst)
        (!rst && ld_mir_i) |=> (r_q.mir == mirror_e'($past(data_i[1:0]))))
        else $error("mirror load mismatch"); // R4
    AST_WIN8_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!rst && !ld_win8_i) |=> $stable(r_q.win8))
        else $error("win8 changed without load"); // R7
    AST_WINA_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!rst && !ld_winA_i) |=> $stable(r_q.winA))
        else $error("winA changed without load"); // R7
    AST_MIR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!rst && !ld_mir_i) |=> $stable(r_q.mir))
        else $error("mirror changed without load"); // R7
    AST_RST_CLEAR: assert property (@(posedge clk)
        rst |=> (r_q == '0))
        else $error("reset did not clear"); // R8

endmodule

// File: rtl/prg_fixed_banks.sv
module prg_fixed_banks #(
    parameter int unsigned BANK_W = 8,
    parameter int unsigned IMPL_W = 6,
    parameter int unsigned N_FIX  = 2
) (
    input  logic [BANK_W:0]   count_i,
    output logic [BANK_W-1:0] bank_o [N_FIX]
);
    localparam int unsigned CNT_W = BANK_W + 1;

    for (genvar g = 0; g < N_FIX; g++) begin : g_fix
        logic [CNT_W-1:0] diff;
        always_comb begin
            diff      = count_i - CNT_W'(N_FIX - g);
            bank_o[g] = BANK_W'(diff[IMPL_W-1:0]);
        end
    end

    always_comb begin
        if (N_FIX > 1) begin
            AST_FIX_ADJ: assert (bank_o[N_FIX-1] ==
                BANK_W'(IMPL_W'(bank_o[N_FIX-2] + 1'b1)))
                else $error("fixed banks not adjacent"); // R3
        end
        AST_FIX_RANGE: assert ((bank_o[0] >> IMPL_W) == '0)
            else $error("fixed bank above implemented width"); // R3
    end

endmodule

// File: rtl/prg_bank_ctl.sv
module prg_bank_ctl
    import prg_ctl_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned BANK_W = PKG_BANK_W,
    parameter int unsigned IMPL_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [BANK_W-1:0] cpu_data,
    input  logic              cpu_wr,
    input  logic [BANK_W:0]   rom_banks,
    output logic [BANK_W-1:0] win8_bank,
    output logic [BANK_W-1:0] winA_bank,
    output logic [BANK_W-1:0] winC_bank,
    output logic [BANK_W-1:0] winE_bank,
    output logic              wram_sel,
    output logic [1:0]        mirror_mode
);
    localparam int unsigned N_FIX = 2;

    logic      ld_win8, ld_winA, ld_mir;
    ctl_regs_t regs;
    logic [BANK_W-1:0] fix_bank [N_FIX];

    prg_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr_i     (cpu_addr),
        .wr_i       (cpu_wr),
        .ld_win8_o  (ld_win8),
        .ld_winA_o  (ld_winA),
        .ld_mir_o   (ld_mir),
        .wram_sel_o (wram_sel)
    );

    prg_bank_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .data_i    (cpu_data),
        .ld_win8_i (ld_win8),
        .ld_winA_i (ld_winA),
        .ld_mir_i  (ld_mir),
        .regs_o    (regs)
    );

    prg_fixed_banks #(.BANK_W(BANK_W), .IMPL_W(IMPL_W), .N_FIX(N_FIX)) u_fix (
        .count_i (rom_banks),
        .bank_o  (fix_bank)
    );

    assign win8_bank   = regs.win8;
    assign winA_bank   = regs.winA;
    assign winC_bank   = fix_bank[0];
    assign winE_bank   = fix_bank[1];
    assign mirror_mode = regs.mir;

    AST_WRAM_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
        wram_sel |-> !(ld_win8 || ld_winA || ld_mir))
        else $error("RAM window hit also loaded a register"); // R6

endmodule

// File: tb/tb_prg_bank_ctl.sv
`timescale 1ns/1ps
module tb_prg_bank_ctl;

    typedef struct {
        string      req;
        logic [7:0] b8;
        logic [7:0] bA;
        logic [1:0] mir;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = 16'h0000;
    logic [7:0]  cpu_data = 8'h00;
    logic        cpu_wr = 1'b0;
    logic [8:0]  rom_banks = 9'd16;
    logic [7:0]  win8_bank, winA_bank, winC_bank, winE_bank;
    logic        wram_sel;
    logic [1:0]  mirror_mode;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    exp_t sb[$];
    logic [7:0] m_b8 = 8'h00, m_bA = 8'h00;
    logic [1:0] m_mir = 2'd0;

    always #2.5 clk = ~clk;

    prg_bank_ctl dut (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .cpu_wr(cpu_wr), .rom_banks(rom_banks), .win8_bank(win8_bank),
        .winA_bank(winA_bank), .winC_bank(winC_bank), .winE_bank(winE_bank),
        .wram_sel(wram_sel), .mirror_mode(mirror_mode)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push_exp(string req);
        exp_t e;
        e.req = req; e.b8 = m_b8; e.bA = m_bA; e.mir = m_mir;
        sb.push_back(e);
    endtask

    // Driver: one bus write, model update from the requirements, expected push
    task automatic bus_write(logic [15:0] a, logic [7:0] d, string req);
        @(negedge clk);
        cpu_addr = a; cpu_data = d; cpu_wr = 1'b1;
        @(posedge clk);
        if (a == 16'h8010) m_b8 = d;
        else if (a == 16'hA010) m_bA = d;
        else if (a == 16'h9400) m_mir = d[1:0];
        push_exp(req);
        #1 cpu_wr = 1'b0;
    endtask

    task automatic idle_cycle(logic [15:0] a, logic [7:0] d, string req);
        @(negedge clk);
        cpu_addr = a; cpu_data = d; cpu_wr = 1'b0;
        @(posedge clk);
        push_exp(req);
    endtask

    // Monitor: pops one expected item per cycle after the edge it belongs to
    initial begin
        forever begin
            @(negedge clk);
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check({e.req, " win8"}, win8_bank, e.b8);
                check({e.req, " winA"}, winA_bank, e.bA);
                check({e.req, " mirror"}, {6'd0, mirror_mode}, {6'd0, e.mir});
            end
        end
    end

    task automatic fixed_case(logic [8:0] n);
        logic [8:0] c2, c1;
        rom_banks = n;
        #1;
        c2 = n - 9'd2; c1 = n - 9'd1;
        check("R3 winC", winC_bank, {2'b00, c2[5:0]});
        check("R3 winE", winE_bank, {2'b00, c1[5:0]});
    endtask

    task automatic ram_case(logic [15:0] a, logic wr, logic exp);
        @(negedge clk);
        cpu_addr = a; cpu_wr = wr; cpu_data = 8'h00;
        #1;
        check("R6 wram_sel", {7'd0, wram_sel}, {7'd0, exp});
        @(posedge clk);
        #1 cpu_wr = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #100000;
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R8 reset win8", win8_bank, 8'h00);
        check("R8 reset winA", winA_bank, 8'h00);
        check("R8 reset mirror", {6'd0, mirror_mode}, 8'h00);
        rst = 1'b0;

        bus_write(16'h8010, 8'hA5, "R1 pattern A5");
        bus_write(16'hA010, 8'h3C, "R2 pattern 3C");
        bus_write(16'h8010, 8'hFF, "R1 all ones");
        bus_write(16'hA010, 8'h00, "R2 all zeros");
        bus_write(16'hA010, 8'h5A, "R2 pattern 5A");
        bus_write(16'h8010, 8'h00, "R1 all zeros");

        bus_write(16'h9400, 8'hFC, "R4 code 0 vertical R5");
        bus_write(16'h9400, 8'h01, "R4 code 1 horizontal R5");
        bus_write(16'h9400, 8'hFE, "R4 code 2 page A R5");
        bus_write(16'h9400, 8'h73, "R4 code 3 page B R5");

        bus_write(16'h8011, 8'h11, "R7 near 8011");
        bus_write(16'h8000, 8'h22, "R7 near 8000");
        bus_write(16'h8018, 8'h33, "R7 near 8018");
        bus_write(16'h0010, 8'h44, "R7 alias 0010");
        bus_write(16'hA000, 8'h55, "R7 near A000");
        bus_write(16'hA011, 8'h66, "R7 near A011");
        bus_write(16'h9401, 8'h00, "R7 near 9401");
        bus_write(16'h9000, 8'h01, "R7 near 9000");
        bus_write(16'hC010, 8'h77, "R7 near C010");
        bus_write(16'h6000, 8'h88, "R7 RAM write");
        idle_cycle(16'h8010, 8'h99, "R7 strobe low 8010");
        idle_cycle(16'hA010, 8'h99, "R7 strobe low A010");
        idle_cycle(16'h9400, 8'h02, "R7 strobe low 9400");

        fixed_case(9'd16);
        fixed_case(9'd64);
        fixed_case(9'd128);
        fixed_case(9'd1);
        fixed_case(9'd2);

        ram_case(16'h6000, 1'b0, 1'b1);
        ram_case(16'h7FFF, 1'b1, 1'b1);
        ram_case(16'h5FFF, 1'b0, 1'b0);
        ram_case(16'h8000, 1'b0, 1'b0);
        ram_case(16'hE000, 1'b0, 1'b0);

        bus_write(16'h8010, 8'hC3, "R1 before reset");
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        m_b8 = 8'h00; m_bA = 8'h00; m_mir = 2'd0;
        push_exp("R8 mid-run reset");
        @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule